// File: doc/BRIEF.md
# MDIO Single-Command Management Engine

This block lets software reach the management registers of an external Ethernet PHY over a two-wire MDIO bus, one Clause 22 access per command. Software first places a 16-bit write value in the data register if needed. It then writes a command word that holds a start flag, a read or write selector, a 5-bit PHY address and a 5-bit register address. The engine serialises the whole management frame on MDC and MDIO and keeps the start flag set while the frame runs. When the frame ends it clears the flag by itself and, for a read, leaves the returned value in the upper half of the data register together with a status bit that tells whether a PHY answered.

MDC is produced from the system clock by a divider and runs only while a frame is in progress. MDIO changes just after MDC falls and is sampled on the system clock edge where MDC rises. During the turnaround and data phases of a read the engine releases the line, so an external pull-up keeps it high unless the PHY drives it.

The frame sequencer is a state machine with the states IDLE, PREAMBLE, START, OPCODE, PHYAD, REGAD, TURN, DATA and DONE. An accepted command moves IDLE to PREAMBLE. On each falling MDC tick that ends a field the machine steps PREAMBLE to START after 32 bits, START to OPCODE after 2, OPCODE to PHYAD after 2, PHYAD to REGAD after 5, REGAD to TURN after 5, TURN to DATA after 2 and DATA to DONE after 16. DONE returns to IDLE on the next clock and hands the result to the register bank in that cycle.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command, data and status registers (register addresses 0, 1 and 2) read as zero, MDC is low and MDIO is released (mdio_oe low). MDC stays low and MDIO stays released whenever no frame is running.
- R2: A command-register write starts a frame only when bit 20 is set together with bit 17 (read) or bit 16 (write); bit 17 wins if both are set. PHY address is taken from bits 12:8 and register address from bits 4:0, and the command register reads these fields back. A write with bit 20 set and neither operation bit set starts nothing.
- R3: Command register bit 20 reads 1 from the cycle after an accepted command until the frame has finished, then clears itself.
- R4: A write frame is 64 MDC cycles of: 32 ones, 01, opcode 01, PHY address, register address, turnaround 10 and data register bits 15:0, each field MSB first. The engine drives MDIO for every bit of it.
- R5: A read frame carries opcode 10. The engine drives the first 46 bits and releases MDIO for the two turnaround bits and the 16 data bits.
- R6: After a read, data register bits 31:16 hold the 16 bits sampled in the data phase (MSB first), and bits 15:0 keep the value software last wrote. Software writes to the data register change only bits 15:0.
- R7: Status register bit 0 is set when a read ends with the second turnaround bit sampled high, and is cleared when a read ends with it low or when a write ends.
- R8: During a frame MDC has a period of 2*DIV_HALF system clocks. MDIO and its enable change only while MDC is low, never while MDC is high.
- R9: A command-register write that arrives while a frame is in progress is ignored: the running frame, its readback fields and the number of MDC cycles are unchanged.
- R10: Each accepted command produces exactly 64 MDC rising edges, and none occur afterwards until the next command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address (0 command, 1 data, 2 status) |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read value, combinational from rd_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_in | input | 1 | MDIO line as seen at the pin |

## Verification
The bound checker watches on every cycle that MDC and the MDIO enable are quiet while idle, that MDIO never moves while MDC is high, that a write frame keeps the line driven, that a valid command starts a frame and an op-less one does not, and that the latched PHY address and operation hold steady for the whole frame. Frame contents bit by bit, the release pattern on reads, the placement of read data in the upper half, the failure status with and without a responding PHY, the MDC period and the exact count of 64 edges can only be shown by the bench's PHY model and scoreboard, which compares each completed command against the frame and register values predicted when it was issued.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_LEN  = 64;
    localparam int PRE_LEN    = 32;
    localparam int ADR_W      = 5;
    localparam int VAL_W      = 16;
    localparam int BIT_START  = 20;
    localparam int BIT_RD     = 17;
    localparam int BIT_WR     = 16;
    localparam int PHY_LSB    = 8;
    // first bit index of each field inside the frame
    localparam int IDX_ST     = PRE_LEN;
    localparam int IDX_OP     = IDX_ST + 2;
    localparam int IDX_PHY    = IDX_OP + 2;
    localparam int IDX_REG    = IDX_PHY + ADR_W;
    localparam int IDX_TA     = IDX_REG + ADR_W;
    localparam int IDX_DATA   = IDX_TA + 2;

    localparam logic [1:0] RA_CMD  = 2'd0;
    localparam logic [1:0] RA_DATA = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE, S_PREAMBLE, S_START, S_OPCODE, S_PHYAD,
        S_REGAD, S_TURN, S_DATA, S_DONE
    } seq_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick      = run && (cnt == CNT_LAST);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rd,
    input  logic [ADR_W-1:0] phy_ad,
    input  logic [ADR_W-1:0] reg_ad,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             mdio_in,
    output logic             busy,
    output logic             done,
    output logic             is_rd,
    output logic [ADR_W-1:0] phy_q,
    output logic [VAL_W-1:0] rd_val,
    output logic             rd_fail,
    output logic             mdio_out,
    output logic             mdio_oe
);
    localparam int IW = $clog2(FRAME_LEN);
    localparam logic [IW-1:0] END_PRE  = IW'(IDX_ST - 1);
    localparam logic [IW-1:0] END_ST   = IW'(IDX_OP - 1);
    localparam logic [IW-1:0] END_OP   = IW'(IDX_PHY - 1);
    localparam logic [IW-1:0] END_PHY  = IW'(IDX_REG - 1);
    localparam logic [IW-1:0] END_REG  = IW'(IDX_TA - 1);
    localparam logic [IW-1:0] END_TA   = IW'(IDX_DATA - 1);
    localparam logic [IW-1:0] END_DATA = IW'(FRAME_LEN - 1);
    localparam logic [IW-1:0] TA_LATE  = IW'(IDX_TA + 1);

    seq_state_e             state, nxt;
    logic [IW-1:0]          idx;
    logic [FRAME_LEN-1:0]   sr;
    logic [VAL_W-1:0]       shift_in;
    logic                   fail_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start)                        nxt = S_PREAMBLE;
            S_PREAMBLE: if (fall_tick && idx == END_PRE)  nxt = S_START;
            S_START:    if (fall_tick && idx == END_ST)   nxt = S_OPCODE;
            S_OPCODE:   if (fall_tick && idx == END_OP)   nxt = S_PHYAD;
            S_PHYAD:    if (fall_tick && idx == END_PHY)  nxt = S_REGAD;
            S_REGAD:    if (fall_tick && idx == END_REG)  nxt = S_TURN;
            S_TURN:     if (fall_tick && idx == END_TA)   nxt = S_DATA;
            S_DATA:     if (fall_tick && idx == END_DATA) nxt = S_DONE;
            S_DONE:                                       nxt = S_IDLE;
            default:                                      nxt = S_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            sr       <= '0;
            shift_in <= '0;
            fail_q   <= 1'b0;
            is_rd    <= 1'b0;
            phy_q    <= '0;
        end else if (state == S_IDLE) begin
            if (start) begin
                sr <= {{PRE_LEN{1'b1}}, 2'b01,
                       (start_rd ? 2'b10 : 2'b01),
                       phy_ad, reg_ad,
                       (start_rd ? 2'b11 : 2'b10),
                       wr_val};
                idx    <= '0;
                fail_q <= 1'b0;
                is_rd  <= start_rd;
                phy_q  <= phy_ad;
            end
        end else if (state != S_DONE) begin
            if (fall_tick) begin
                sr  <= {sr[FRAME_LEN-2:0], 1'b0};
                idx <= idx + IW'(1);
            end
            if (rise_tick && is_rd) begin
                if (state == S_TURN && idx == TA_LATE)
                    fail_q <= mdio_in;
                if (state == S_DATA)
                    shift_in <= {shift_in[VAL_W-2:0], mdio_in};
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        mdio_out = sr[FRAME_LEN-1];
        rd_val   = shift_in;
        rd_fail  = fail_q;
        unique case (state)
            S_IDLE, S_DONE: mdio_oe = 1'b0;
            S_TURN, S_DATA: mdio_oe = !is_rd;
            default:        mdio_oe = 1'b1;
        endcase
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic             busy,
    input  logic             done,
    input  logic             seq_rd,
    input  logic [VAL_W-1:0] rd_val,
    input  logic             rd_fail,
    output logic             start,
    output logic             start_rd,
    output logic [ADR_W-1:0] phy_ad,
    output logic [ADR_W-1:0] reg_ad,
    output logic [VAL_W-1:0] wr_val
);
    logic [ADR_W-1:0] cmd_phy_q, cmd_reg_q;
    logic             cmd_rd_q, cmd_wr_q;
    logic [31:0]      data_q;
    logic             stat_q;
    logic             cmd_wr;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[31:21], wr_data[19:18], wr_data[7:5]};

    assign cmd_wr   = wr_en && (wr_addr == RA_CMD);
    assign start    = cmd_wr && !busy && wr_data[BIT_START]
                      && (wr_data[BIT_RD] || wr_data[BIT_WR]);
    assign start_rd = wr_data[BIT_RD];
    assign phy_ad   = wr_data[PHY_LSB +: ADR_W];
    assign reg_ad   = wr_data[ADR_W-1:0];
    assign wr_val   = data_q[VAL_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_phy_q <= '0;
            cmd_reg_q <= '0;
            cmd_rd_q  <= 1'b0;
            cmd_wr_q  <= 1'b0;
            data_q    <= '0;
            stat_q    <= 1'b0;
        end else begin
            if (start) begin
                cmd_phy_q <= phy_ad;
                cmd_reg_q <= reg_ad;
                cmd_rd_q  <= start_rd;
                cmd_wr_q  <= !start_rd;
            end
            if (wr_en && wr_addr == RA_DATA)
                data_q[VAL_W-1:0] <= wr_data[VAL_W-1:0];
            if (done) begin
                stat_q <= seq_rd && rd_fail;
                if (seq_rd)
                    data_q[31:VAL_W] <= rd_val;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CMD: begin
                rd_data[BIT_START]           = busy;
                rd_data[BIT_RD]              = cmd_rd_q;
                rd_data[BIT_WR]              = cmd_wr_q;
                rd_data[PHY_LSB +: ADR_W]    = cmd_phy_q;
                rd_data[ADR_W-1:0]           = cmd_reg_q;
            end
            RA_DATA: rd_data = data_q;
            RA_STAT: rd_data[0] = stat_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic             start, start_rd;
    logic [ADR_W-1:0] phy_ad, reg_ad, seq_phy;
    logic [VAL_W-1:0] wr_val, rd_val;
    logic             seq_busy, seq_done, seq_rd, rd_fail;
    logic             rise_tick, fall_tick;

    mdio_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(seq_busy), .done(seq_done), .seq_rd(seq_rd),
        .rd_val(rd_val), .rd_fail(rd_fail),
        .start(start), .start_rd(start_rd),
        .phy_ad(phy_ad), .reg_ad(reg_ad), .wr_val(wr_val)
    );

    mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(seq_busy),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_rd(start_rd),
        .phy_ad(phy_ad), .reg_ad(reg_ad), .wr_val(wr_val),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_in(mdio_in),
        .busy(seq_busy), .done(seq_done), .is_rd(seq_rd), .phy_q(seq_phy),
        .rd_val(rd_val), .rd_fail(rd_fail),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic        busy,
    input logic        done,
    input logic        seq_rd,
    input logic [4:0]  seq_phy,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_addr == 2'd0) && !busy;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data[20] && (wr_data[17] || wr_data[16])) |=> busy);

    p_no_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !wr_data[17] && !wr_data[16]) |=> !busy);

    p_write_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_rd && !done) |-> mdio_oe);

    p_high_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    p_hold_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(seq_phy) && $stable(seq_rd)));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .busy(seq_busy), .done(seq_done),
    .seq_rd(seq_rd), .seq_phy(seq_phy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/mdio_cmd_engine_tb.sv
module mdio_cmd_engine_tb;
    localparam int DIVH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_out, mdio_oe, line;

    logic        phy_present = 1'b0;
    logic [15:0] phy_val = '0;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;
    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    int          k = 0;
    time         last_rise = 0;
    time         rise_per = 0;

    int total = 0;
    int fails = 0;
    logic [15:0] low_model = '0;
    logic [15:0] high_model = '0;

    typedef struct {
        logic [63:0] frame;
        logic [63:0] oe;
        logic [31:0] data;
        logic        stat;
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  rg;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;

    assign line = mdio_oe ? mdio_out : (phy_en ? phy_bit : 1'b1);

    mdio_cmd_engine #(.DIV_HALF(DIVH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(line)
    );

    // PHY model: capture on rising MDC, answer on falling MDC
    always @(posedge mdc) begin
        if (k < 64) begin
            cap[63-k]   = line;
            oecap[63-k] = mdio_oe;
        end
        if (k > 0) rise_per = $time - last_rise;
        last_rise = $time;
        k = k + 1;
    end

    always @(negedge mdc) begin
        if (phy_present && cap[29:28] == 2'b10 && k >= 47 && k <= 63) begin
            phy_en  = 1'b1;
            phy_bit = (k == 47) ? 1'b0 : phy_val[15-(k-48)];
        end else begin
            phy_en  = 1'b0;
            phy_bit = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // driver: predicts the result and pushes it before issuing the command
    task automatic issue(input bit rd, input bit both, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wval, input bit present, input logic [15:0] pval);
        item_t it;
        reg_wr(2'd1, {16'hDEAD, wval});
        low_model = wval;
        phy_present = present; phy_val = pval; k = 0; cap = '0; oecap = '0;
        if (rd) begin
            it.frame = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 1'b1, !present,
                        present ? pval : 16'hFFFF};
            it.oe    = {{46{1'b1}}, 18'd0};
            high_model = present ? pval : 16'hFFFF;
            it.stat  = !present;
        end else begin
            it.frame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, wval};
            it.oe    = {64{1'b1}};
            it.stat  = 1'b0;
        end
        it.data = {high_model, low_model};
        it.rd = rd; it.phy = phy; it.rg = rg;
        q.push_back(it);
        reg_wr(2'd0, (32'h1 << 20) | (rd ? (32'h1 << 17) : 32'h0)
                     | ((!rd || both) ? (32'h1 << 16) : 32'h0)
                     | ({27'd0, phy} << 8) | {27'd0, rg});
    endtask

    // monitor: waits for each command to finish and compares with the queue head
    initial begin
        forever begin
            item_t it;
            logic [31:0] d;
            int n;
            wait (q.size() != 0);
            it = q[0];
            repeat (2) @(negedge clk);
            reg_rd(2'd0, d);
            chk("R3 busy set", {63'd0, d[20]}, 64'd1);
            chk("R2 fields", {32'd0, d[17], d[16], d[12:8], d[4:0]},
                {32'd0, it.rd, !it.rd, it.phy, it.rg});
            n = 0;
            while (d[20] && n < 2000) begin
                reg_rd(2'd0, d);
                n++;
            end
            chk("R3 busy cleared", {63'd0, d[20]}, 64'd0);
            chk("R2 fields held", {54'd0, d[12:8], d[4:0]}, {54'd0, it.phy, it.rg});
            chk(it.rd ? "R5 read frame" : "R4 write frame", cap, it.frame);
            chk(it.rd ? "R5 release" : "R4 driven", oecap, it.oe);
            chk("R10 edge count", 64'(k), 64'd64);
            chk("R8 mdc period", 64'(rise_per), 64'(2 * DIVH * 20));
            reg_rd(2'd1, d);
            chk("R6 data reg", {32'd0, d}, {32'd0, it.data});
            reg_rd(2'd2, d);
            chk("R7 status", {32'd0, d}, {63'd0, it.stat});
            void'(q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_rd(2'd0, d); chk("R1 cmd reset", {32'd0, d}, 64'd0);
        reg_rd(2'd1, d); chk("R1 data reset", {32'd0, d}, 64'd0);
        reg_rd(2'd2, d); chk("R1 status reset", {32'd0, d}, 64'd0);
        chk("R1 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);

        issue(1'b0, 1'b0, 5'd5, 5'd3, 16'hBEEF, 1'b0, 16'h0);
        wait (q.size() == 0);
        issue(1'b1, 1'b0, 5'd1, 5'd2, 16'h0042, 1'b1, 16'h1234);
        wait (q.size() == 0);
        issue(1'b1, 1'b0, 5'd31, 5'd31, 16'h7777, 1'b0, 16'h0);
        wait (q.size() == 0);
        // R7: a write clears the failure flag
        issue(1'b0, 1'b0, 5'd0, 5'd0, 16'h0001, 1'b0, 16'h0);
        wait (q.size() == 0);
        // R2: both operation bits set selects read
        issue(1'b1, 1'b1, 5'd10, 5'd17, 16'h00FF, 1'b1, 16'h8001);
        wait (q.size() == 0);

        // R2: start without an operation bit does nothing
        k = 0;
        reg_wr(2'd0, 32'h0010_0A05);
        repeat (40) @(negedge clk);
        reg_rd(2'd0, d);
        chk("R2 no-op busy", {63'd0, d[20]}, 64'd0);
        chk("R2 no-op no mdc", 64'(k), 64'd0);

        // R9: command written mid-frame is ignored
        issue(1'b1, 1'b0, 5'd9, 5'd4, 16'h5A5A, 1'b1, 16'hA5C3);
        repeat (20) @(negedge clk);
        reg_wr(2'd0, 32'h0011_1F1F);
        wait (q.size() == 0);
        repeat (100) @(negedge clk);
        chk("R9 no extra frame", 64'(k), 64'd64);
        reg_rd(2'd0, d);
        chk("R9 fields unchanged", {55'd0, d[20], d[12:8], d[4:0]}, {55'd0, 1'b0, 5'd9, 5'd4});
        chk("R1 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule